// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-interface master for an Ethernet PHY. It drives the management clock and a bidirectional data line, and software controls it through a small register port. To start a transfer, software first sets the clock divisor and the preamble option. It then writes the PHY address, the register address and, for a write, the 16-bit data. Finally it sets a command bit. The block sends the serial management frame. On a read it captures the data the PHY returns, and it reports busy, invalid and link-fail status.

A scan mode keeps reading PHY register 1 at the programmed PHY address, one read after another. After each read it copies the inverted link-status bit into the link-fail flag, so software can watch the link without sending commands itself. The clock divisor is always even and is never below 2. Software picks it so that the management clock stays at or below 2.5 MHz.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads zero, the management clock is low and the data line is not driven (`mdio_oe_o` = 0).
- R2: The divisor field is bits 7:0 of the mode register (offset 0), and bit 0 always reads back as zero. The effective divisor D is the stored value, or 2 when the stored value is zero. The management clock is high for D/2 system cycles and low for D/2 system cycles.
- R3: Writing command bit 2 (write) at offset 1 sends a frame with the data line driven throughout. The frame is: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, then the 16 data bits MSB first. Each bit is presented while the clock is low and is held while the clock is high.
- R4: Mode register bit 8 set removes the 32-bit preamble, so the frame is 32 clock periods long.
- R5: Command bit 1 (read) sends start 01 and opcode 10, followed by the two address fields. The data line is released from the turnaround onward. The 16 data bits are sampled at the rising clock edges that follow, MSB first, and land in the read-data register (offset 4).
- R6: Busy (status bit 1, offset 5) goes high when a command is accepted and stays high until the frame completes. While busy is low, the clock stays low and the line is released.
- R7: A read or write command written while busy is high is ignored: no extra frame is sent and the read data is unchanged.
- R8: Command bit 0 (scan), written as 1, raises busy and invalid (status bit 2). The block then reads register 1 repeatedly. After each read, link fail (status bit 0) becomes the inverse of bit 2 of the data, and invalid clears after the first result. Writing 0 ends the scan once the current frame is done.
- R9: The address register (offset 2) holds the PHY address in bits 4:0 and the register address in bits 12:8. The write-data register is at offset 3. Both read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor, a 32-bit preamble and 16-bit data. It sweeps divisor values 0 through 12, including the odd values, so the rounding to an even divisor and the zero-becomes-2 case can be measured in every frame. Each divisor is run with both read and write frames, with and without preamble. A PHY model in the bench answers reads and scan reads, so every frame bit, the turnaround release and the captured data can be compared against values the bench builds itself.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
  localparam int unsigned REG_AW = 3;
  localparam logic [REG_AW-1:0] RA_MODE  = 3'd0;
  localparam logic [REG_AW-1:0] RA_CMD   = 3'd1;
  localparam logic [REG_AW-1:0] RA_ADDR  = 3'd2;
  localparam logic [REG_AW-1:0] RA_WDATA = 3'd3;
  localparam logic [REG_AW-1:0] RA_RDATA = 3'd4;
  localparam logic [REG_AW-1:0] RA_STAT  = 3'd5;

  localparam int unsigned CMD_SCAN  = 0;
  localparam int unsigned CMD_READ  = 1;
  localparam int unsigned CMD_WRITE = 2;
  localparam int unsigned ST_LINKFAIL = 0;
  localparam int unsigned ST_BUSY     = 1;
  localparam int unsigned ST_INVALID  = 2;
  localparam int unsigned REG_FLD_OFS = 8;

  localparam logic [1:0] SOF   = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] TA_WR = 2'b10;

  typedef enum logic [1:0] {K_WRITE, K_READ, K_SCAN} xfer_kind_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int unsigned HALF_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              mdc_o,
  output logic              rise_o,
  output logic              fall_o
);
  logic [HALF_W-1:0] cnt_q;
  logic              mdc_q;
  logic              term;

  assign term   = (cnt_q == half_i - HALF_W'(1));
  assign rise_o = en_i & term & ~mdc_q;
  assign fall_o = en_i & term & mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_master_pkg::*;
#(
  parameter int unsigned PHY_AW  = 5,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic              nopre_i,
  input  logic [PHY_AW-1:0] phy_i,
  input  logic [PHY_AW-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              run_o,
  output logic              done_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned FRM_W      = 6 + 2*PHY_AW + DATA_W;
  localparam int unsigned POS_W      = $clog2(PRE_LEN + FRM_W);
  localparam int unsigned DATA_AT    = FRM_W - DATA_W;
  localparam int unsigned RELEASE_AT = DATA_AT - 2;

  logic [FRM_W-1:0]  frame_q;
  logic [POS_W-1:0]  pos_q;
  logic [DATA_W-1:0] sh_q;
  logic              run_q, rd_q, nopre_q;
  logic [POS_W-1:0]  pre_len, last_pos, fidx;
  logic              in_pre, released, last;

  assign pre_len  = nopre_q ? '0 : POS_W'(PRE_LEN);
  assign last_pos = pre_len + POS_W'(FRM_W - 1);
  assign in_pre   = pos_q < pre_len;
  assign fidx     = pos_q - pre_len;
  assign released = rd_q & ~in_pre & (fidx >= POS_W'(RELEASE_AT));
  assign last     = pos_q == last_pos;

  assign run_o     = run_q;
  assign done_o    = run_q & fall_i & last;
  assign mdio_o    = ~run_q | in_pre | frame_q[FRM_W-1];
  assign mdio_oe_o = run_q & ~released;
  assign rdata_o   = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      rd_q    <= 1'b0;
      nopre_q <= 1'b0;
      pos_q   <= '0;
      frame_q <= '0;
      sh_q    <= '0;
    end else if (!run_q) begin
      if (start_i) begin
        run_q   <= 1'b1;
        rd_q    <= rd_i;
        nopre_q <= nopre_i;
        pos_q   <= '0;
        frame_q <= {SOF, rd_i ? OP_RD : OP_WR, phy_i, reg_i,
                    rd_i ? 2'b11 : TA_WR, rd_i ? {DATA_W{1'b1}} : wdata_i};
      end
    end else begin
      if (rise_i && rd_q && !in_pre && fidx >= POS_W'(DATA_AT))
        sh_q <= {sh_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last) run_q <= 1'b0;
        else      pos_q <= pos_q + POS_W'(1);
        if (!in_pre) frame_q <= frame_q << 1;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned PHY_AW   = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned PRE_LEN  = 32,
  parameter int unsigned SCAN_REG = 1,
  parameter int unsigned LINK_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int unsigned HALF_W = DIV_W - 1;

  logic [DIV_W-1:0]  div_q;
  logic              nopre_q;
  logic [PHY_AW-1:0] phy_q, rga_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic              scan_q, link_fail_q, invalid_q;
  xfer_kind_e        kind_q;

  logic [HALF_W-1:0] half;
  logic              busy, cmd_we, rw_go, scan_go, eng_start, start_rd;
  logic              eng_run, eng_done, rise, fall;
  logic [PHY_AW-1:0] start_reg;
  logic [DATA_W-1:0] eng_rdata;

  // divisor 0 behaves as 2
  assign half = (div_q[DIV_W-1:1] == '0) ? HALF_W'(1) : div_q[DIV_W-1:1];

  assign busy      = eng_run | scan_q;
  assign cmd_we    = reg_we_i && (reg_addr_i == RA_CMD);
  assign rw_go     = cmd_we && !busy &&
                     (reg_wdata_i[CMD_WRITE] || reg_wdata_i[CMD_READ]);
  assign scan_go   = scan_q & ~eng_run;
  assign eng_start = rw_go | scan_go;
  assign start_rd  = rw_go ? ~reg_wdata_i[CMD_WRITE] : 1'b1;
  assign start_reg = rw_go ? rga_q : PHY_AW'(SCAN_REG);

  mdio_clk_gen #(.HALF_W(HALF_W)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (eng_run),
    .half_i (half),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_engine #(.PHY_AW(PHY_AW), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (eng_start),
    .rd_i      (start_rd),
    .nopre_i   (nopre_q),
    .phy_i     (phy_q),
    .reg_i     (start_reg),
    .wdata_i   (wdat_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .run_o     (eng_run),
    .done_o    (eng_done),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rdata_o   (eng_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q       <= '0;
      nopre_q     <= 1'b0;
      phy_q       <= '0;
      rga_q       <= '0;
      wdat_q      <= '0;
      rdat_q      <= '0;
      scan_q      <= 1'b0;
      link_fail_q <= 1'b0;
      invalid_q   <= 1'b0;
      kind_q      <= K_WRITE;
    end else begin
      if (reg_we_i) begin
        unique case (reg_addr_i)
          RA_MODE: begin
            div_q   <= {reg_wdata_i[DIV_W-1:1], 1'b0};
            nopre_q <= reg_wdata_i[DIV_W];
          end
          RA_ADDR: begin
            phy_q <= reg_wdata_i[PHY_AW-1:0];
            rga_q <= reg_wdata_i[REG_FLD_OFS +: PHY_AW];
          end
          RA_WDATA: wdat_q <= reg_wdata_i;
          default: ;
        endcase
      end
      if (eng_start)
        kind_q <= !rw_go ? K_SCAN : (start_rd ? K_READ : K_WRITE);
      if (eng_done && kind_q != K_WRITE) begin
        rdat_q <= eng_rdata;
        if (kind_q == K_SCAN) begin
          link_fail_q <= ~eng_rdata[LINK_BIT];
          invalid_q   <= 1'b0;
        end
      end
      if (cmd_we) begin
        scan_q <= reg_wdata_i[CMD_SCAN];
        if (reg_wdata_i[CMD_SCAN] && !scan_q) invalid_q <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_MODE: begin
        reg_rdata_o[DIV_W-1:0] = div_q;
        reg_rdata_o[DIV_W]     = nopre_q;
      end
      RA_CMD:  reg_rdata_o[CMD_SCAN] = scan_q;
      RA_ADDR: begin
        reg_rdata_o[PHY_AW-1:0]             = phy_q;
        reg_rdata_o[REG_FLD_OFS +: PHY_AW] = rga_q;
      end
      RA_WDATA: reg_rdata_o = wdat_q;
      RA_RDATA: reg_rdata_o = rdat_q;
      RA_STAT: begin
        reg_rdata_o[ST_LINKFAIL] = link_fail_q;
        reg_rdata_o[ST_BUSY]     = busy;
        reg_rdata_o[ST_INVALID]  = invalid_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned HALF_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mdc_i,
  input logic              mdio_i,
  input logic              oe_i,
  input logic              busy_i,
  input logic              invalid_i,
  input logic [HALF_W-1:0] half_i
);
  logic [HALF_W-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt_q <= '0;
    else         hi_cnt_q <= mdc_i ? hi_cnt_q + HALF_W'(1) : '0;
  end

  p_high_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdc_i) |-> hi_cnt_q == half_i);

  p_hold_while_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_i && $past(mdc_i)) |-> ($stable(mdio_i) && $stable(oe_i)));

  p_idle_clock_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i);

  p_idle_released_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !oe_i);

  p_invalid_in_scan_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_i |-> busy_i);
endmodule

bind mdio_master mdio_master_chk #(.HALF_W(DIV_W - 1)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mdc_i     (mdc_o),
  .mdio_i    (mdio_o),
  .oe_i      (mdio_oe_o),
  .busy_i    (busy),
  .invalid_i (invalid_q),
  .half_i    (half)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  import mdio_master_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = RA_STAT;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  mdio_master dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .mdc_o       (mdc),
    .mdio_o      (mdio_out),
    .mdio_oe_o   (mdio_oe),
    .mdio_i      (mdio_in)
  );

  // monitor: capture each bit at the rising MDC edge
  int   rc = 0;
  int   rc_base = 0;
  int   hi_len = 0;
  int   last_hi = 0;
  logic prev_mdc = 1'b0;
  logic cap_b  [0:255];
  logic cap_oe [0:255];

  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin
      cap_b[rc % 256]  = mdio_out;
      cap_oe[rc % 256] = mdio_oe;
      rc++;
    end
    if (mdc) hi_len++;
    else if (prev_mdc) begin
      last_hi = hi_len;
      hi_len  = 0;
    end
    prev_mdc = mdc;
  end

  // PHY model: answers read frames with phy_data
  int          cur_pre = 32;
  bit          phy_rd = 1'b0;
  logic [15:0] phy_data = '0;
  int          rel;
  always_comb begin
    rel     = (rc - rc_base) % (cur_pre + 32);
    mdio_in = 1'b1;
    if (phy_rd && rel >= cur_pre + 16 && rel < cur_pre + 32)
      mdio_in = phy_data[15 - (rel - cur_pre - 16)];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = RA_STAT;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_stat(input int idx, input logic val, input int max, output bit ok);
    logic [15:0] r;
    ok = 1'b0;
    for (int i = 0; i < max; i++) begin
      rd(RA_STAT, r);
      if (r[idx] == val) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic do_frame(input bit is_rd, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] d, input bit np, input logic [7:0] div);
    logic [15:0] r, exp_mode;
    logic [31:0] w;
    int half, pre, bad, badoe;
    bit ok, eb, eo;
    exp_mode = {7'b0, np, div & 8'hFE};
    half = ((div & 8'hFE) == 0) ? 1 : (div & 8'hFE) / 2;
    pre  = np ? 0 : 32;
    wr(RA_MODE, {7'b0, np, div});
    rd(RA_MODE, r);
    chk(r == exp_mode, "R2", "mode readback even divisor", r, exp_mode);
    wr(RA_ADDR, {3'b0, rg, 3'b0, phy});
    wr(RA_WDATA, d);
    rd(RA_ADDR, r);
    chk(r == {3'b0, rg, 3'b0, phy}, "R9", "address readback", r, {3'b0, rg, 3'b0, phy});
    rd(RA_WDATA, r);
    chk(r == d, "R9", "write data readback", r, d);
    cur_pre  = pre;
    phy_rd   = is_rd;
    phy_data = d ^ 16'hA5C3;
    rc_base  = rc;
    wr(RA_CMD, is_rd ? 16'h0002 : 16'h0004);
    rd(RA_STAT, r);
    chk(r[1] == 1'b1, "R6", "busy after command", r[1], 1);
    wait_stat(1, 1'b0, 4000, ok);
    chk(ok, "R6", "busy clears after frame", ok, 1);
    chk(rc - rc_base == pre + 32, np ? "R4" : "R3", "frame length", rc - rc_base, pre + 32);
    w = {2'b01, is_rd ? 2'b10 : 2'b01, phy, rg, 2'b10, d};
    bad = 0;
    badoe = 0;
    for (int k = 0; k < pre + 32; k++) begin
      eb = (k < pre) ? 1'b1 : w[31 - (k - pre)];
      eo = !(is_rd && k >= pre + 14);
      if (cap_oe[(rc_base + k) % 256] != eo) badoe++;
      if (eo && cap_b[(rc_base + k) % 256] != eb) bad++;
    end
    chk(bad == 0, is_rd ? "R5" : "R3", "frame bit mismatches", bad, 0);
    chk(badoe == 0, is_rd ? "R5" : "R3", "drive enable mismatches", badoe, 0);
    chk(last_hi == half, "R2", "mdc high phase cycles", last_hi, half);
    if (is_rd) begin
      rd(RA_RDATA, r);
      chk(r == phy_data, "R5", "captured read data", r, phy_data);
    end
    chk(!mdc && !mdio_oe, "R6", "idle clock low and released", {mdc, mdio_oe}, 0);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] r, held;
    bit ok;
    int snap;
    logic [31:0] w;
    int bad;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), r);
      chk(r == 16'h0, "R1", $sformatf("reg %0d after reset", a), r, 0);
    end
    chk(!mdc && !mdio_oe, "R1", "pins after reset", {mdc, mdio_oe}, 0);

    // sweep divisors, both opcodes, preamble on/off
    for (int dv = 0; dv <= 12; dv++) begin
      do_frame(1'b0, 5'(dv * 3 + 1), 5'(31 - dv), 16'(16'h8001 ^ (dv * 16'h1357)), dv[0], 8'(dv));
      do_frame(1'b1, 5'(dv * 5 + 2), 5'(dv * 7), 16'(16'h7FFE ^ (dv * 16'h2469)), ~dv[0], 8'(dv));
    end

    // R7 commands while busy are ignored
    rd(RA_RDATA, held);
    wr(RA_MODE, 16'h0008);
    wr(RA_ADDR, 16'h0203);
    wr(RA_WDATA, 16'hBEEF);
    cur_pre = 32;
    phy_rd  = 1'b0;
    rc_base = rc;
    wr(RA_CMD, 16'h0004);
    repeat (40) @(negedge clk);
    wr(RA_CMD, 16'h0002);
    wr(RA_CMD, 16'h0004);
    wait_stat(1, 1'b0, 4000, ok);
    repeat (200) @(negedge clk);
    chk(rc - rc_base == 64, "R7", "rising edges for one frame only", rc - rc_base, 64);
    rd(RA_STAT, r);
    chk(r[1] == 1'b0, "R7", "idle after ignored commands", r[1], 0);
    rd(RA_RDATA, r);
    chk(r == held, "R7", "read data untouched", r, held);

    // R8 scan
    wr(RA_MODE, 16'h0102);
    wr(RA_ADDR, 16'h0309);
    cur_pre  = 0;
    phy_rd   = 1'b1;
    phy_data = 16'h1230;
    rc_base  = rc;
    wr(RA_CMD, 16'h0001);
    rd(RA_STAT, r);
    chk(r[2:1] == 2'b11, "R8", "invalid and busy at scan start", r[2:1], 3);
    wait_stat(2, 1'b0, 4000, ok);
    chk(ok, "R8", "invalid clears after first scan", ok, 1);
    rd(RA_STAT, r);
    chk(r[0] == 1'b1, "R8", "link fail from link bit 0", r[0], 1);
    w = {2'b01, 2'b10, 5'd9, 5'd1, 2'b11, 16'h0};
    bad = 0;
    for (int k = 0; k < 14; k++)
      if (cap_b[(rc_base + k) % 256] != w[31 - k]) bad++;
    chk(bad == 0, "R8", "scan frame header targets register 1", bad, 0);
    rd(RA_RDATA, r);
    chk(r == 16'h1230, "R8", "scan data in read register", r, 16'h1230);
    phy_data = 16'h0004;
    wait_stat(0, 1'b0, 4000, ok);
    chk(ok, "R8", "link fail clears when link bit set", ok, 1);
    rd(RA_STAT, r);
    chk(r[1] == 1'b1, "R8", "busy while scanning", r[1], 1);
    snap = rc;
    wr(RA_CMD, 16'h0000);
    wait_stat(1, 1'b0, 4000, ok);
    repeat (100) @(negedge clk);
    rd(RA_STAT, r);
    chk(r == 16'h0, "R8", "status after scan stop", r, 0);
    chk(rc - snap <= 32, "R8", "scan halts after current frame", rc - snap, 32);
    chk(!mdc && !mdio_oe, "R6", "pins idle after scan", {mdc, mdio_oe}, 0);

    finish_run();
  end
endmodule